// File: doc/BRIEF.md
# Fail-safe window watchdog supervisor

This block supervises a host processor. It counts milliseconds from a free-running oscillator tick and expects the host to write a fixed redundant service code at the right moment. Three behaviours are selectable. Window mode rejects a service that comes too early. Time-out mode accepts a service at any point before the period ends. Off mode lets the counter run on the longest period and raise an interrupt instead of a reset. Any violation produces a one-cycle reset request, and the block then re-enters a start-up phase.

The period is picked from one of two tables. The running table applies in the run, flash and standby operating states, and the sleep table applies in the sleep state. The host changes mode and period through a configuration strobe. A sticky flag records that the watchdog caused the most recent reset. Reading the flag clears it.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, `wd_rst_req`, `wd_irq` and `wd_caused` are all 0. On release the block is in the start-up phase with the default configuration: window mode, select 0.
- R2: In the start-up phase, a valid service write takes the block into the running phase. If INIT_MS milliseconds pass after reset release, or after a watchdog reset request, with no valid service, a new reset request is raised and start-up begins again.
- R3: A service write is valid only when its code equals SVC_KEY (default 8'h5A, upper half the bitwise complement of lower half). Outside off mode, any other code requests a reset at the write's clock edge, whether the block is in start-up or running.
- R4: In window mode, a valid service written while fewer than half the period's milliseconds have elapsed requests a reset at that edge.
- R5: In window mode, a valid service written once at least half the period has elapsed restarts the period from zero.
- R6: If no valid service arrives by the end of the period, `wd_rst_req` pulses for one cycle at the edge where the last millisecond ends, and the start-up phase begins. One millisecond is OSC_PER_MS oscillator ticks.
- R7: In time-out mode, a valid service at any elapsed time restarts the period.
- R8: In the running table, period select 0..7 gives 20, 40, 80, 160, 320, 640, 1024 and 2048 ms.
- R9: When `op_state` is sleep (2'b10), the sleep table applies: 160, 320, 640, 1024, 2048, 3072, 4096 and 28672 ms. A window configuration then behaves as time-out.
- R10: Mode codes are 00 off, 01 window and 10 time-out. A configuration write with mode 11 requests a reset at that edge and leaves the stored mode and select unchanged.
- R11: In off mode during the running phase, the period is 28672 ms. Its end pulses `wd_irq` for one cycle, not a reset, and restarts the period. Service writes of any code are ignored.
- R12: `wd_caused` is set with every watchdog reset request. It is cleared at the edge after a `stat_rd` strobe, and a simultaneous reset request wins over the clear.
- R13: A legal configuration write in the running phase restarts the period from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle pulse per watchdog oscillator period |
| svc_valid | input | 1 | Service write strobe |
| svc_code | input | SVC_W | Service code carried by the write |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Requested mode: 00 off, 01 window, 10 time-out, 11 illegal |
| cfg_sel | input | 3 | Period select index |
| op_state | input | 2 | Operating state: 00 run, 01 flash, 10 sleep, 11 standby |
| stat_rd | input | 1 | Read strobe that clears the cause flag |
| wd_rst_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | One-cycle interrupt at the end of an off-mode period |
| wd_caused | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
The bench builds the block with OSC_PER_MS = 1 and INIT_MS = 30, so every clock with `osc_tick` high counts as one millisecond. This makes the longest entries reachable within a short run: the 28672 ms off-mode interrupt, the 3072 ms sleep period and the 2048 ms window boundary. The short start-up period lets the bench re-arm the block quickly after each of the many reset requests. Because the divider is set to 1, the bench builds the pass-through tick variant, and the counting divider is built only with the default parameters.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [1:0] {
      WM_OFF     = 2'b00,
      WM_WINDOW  = 2'b01,
      WM_TIMEOUT = 2'b10,
      WM_ILLEGAL = 2'b11
   } wd_mode_e;

   typedef enum logic [1:0] {
      OS_RUN     = 2'b00,
      OS_FLASH   = 2'b01,
      OS_SLEEP   = 2'b10,
      OS_STANDBY = 2'b11
   } op_state_e;

   typedef enum logic {
      PH_START = 1'b0,
      PH_RUN   = 1'b1
   } wd_phase_e;

   localparam int unsigned SEL_W      = 3;
   localparam int unsigned LONGEST_MS = 28672;
   localparam int unsigned PER_W      = 16;

   // Running-state table: doubling from 20 ms for six codes, then 1024 and 2048.
   function automatic logic [PER_W-1:0] run_period_ms(input logic [SEL_W-1:0] sel);
      if (sel < 3'd6) return PER_W'(20) << sel;
      return PER_W'(1024) << (sel - 3'd6);
   endfunction

   function automatic logic [PER_W-1:0] sleep_period_ms(input logic [SEL_W-1:0] sel);
      case (sel)
         3'd0:    return PER_W'(160);
         3'd1:    return PER_W'(320);
         3'd2:    return PER_W'(640);
         3'd3:    return PER_W'(1024);
         3'd4:    return PER_W'(2048);
         3'd5:    return PER_W'(3072);
         3'd6:    return PER_W'(4096);
         default: return PER_W'(LONGEST_MS);
      endcase
   endfunction

   function automatic logic [PER_W-1:0] period_ms(input logic sleep, input logic [SEL_W-1:0] sel);
      return sleep ? sleep_period_ms(sel) : run_period_ms(sel);
   endfunction

endpackage

// File: rtl/wdog_tickgen.sv
module wdog_tickgen #(
   parameter int unsigned OSC_PER_MS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   output logic ms_tick
);

   if (OSC_PER_MS == 1) begin : g_direct
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign ms_tick        = osc_tick;
   end else begin : g_div
      localparam int unsigned DW = $clog2(OSC_PER_MS);
      logic [DW-1:0] div_q;
      logic          last;

      assign last    = (div_q == DW'(OSC_PER_MS - 1));
      assign ms_tick = osc_tick && last;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (osc_tick) begin
            div_q <= last ? '0 : div_q + DW'(1);
         end
      end
   end

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
   import wdog_pkg::*;
#(
   parameter int unsigned MS_W     = 15,
   parameter logic [1:0]  DEF_MODE = 2'b01,
   parameter int unsigned DEF_SEL  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic [1:0]       cfg_mode,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [1:0]       op_state,
   output wd_mode_e         eff_mode,
   output logic [MS_W-1:0]  limit_ms,
   output logic             cfg_restart,
   output logic             cfg_illegal
);

   wd_mode_e         mode_q;
   logic [SEL_W-1:0] sel_q;
   logic             in_sleep;

   assign in_sleep    = (op_state_e'(op_state) == OS_SLEEP);
   assign cfg_illegal = cfg_valid && (wd_mode_e'(cfg_mode) == WM_ILLEGAL);
   assign cfg_restart = cfg_valid && !cfg_illegal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= wd_mode_e'(DEF_MODE);
         sel_q  <= SEL_W'(DEF_SEL);
      end else if (cfg_restart) begin
         mode_q <= wd_mode_e'(cfg_mode);
         sel_q  <= cfg_sel;
      end
   end

   always_comb begin
      eff_mode = mode_q;
      if (in_sleep && mode_q == WM_WINDOW) eff_mode = WM_TIMEOUT;
      limit_ms = MS_W'(period_ms(in_sleep, sel_q));
   end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int unsigned     MS_W    = 15,
   parameter int unsigned     INIT_MS = 256,
   parameter int unsigned     SVC_W   = 8,
   parameter logic [SVC_W-1:0] SVC_KEY = 'h5A
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             svc_valid,
   input  logic [SVC_W-1:0] svc_code,
   input  wd_mode_e         eff_mode,
   input  logic [MS_W-1:0]  limit_ms,
   input  logic             cfg_restart,
   input  logic             cfg_illegal,
   input  logic             stat_rd,
   output logic             rst_req,
   output logic             irq,
   output logic             caused,
   output logic             off_run
);

   wd_phase_e       phase_q;
   logic [MS_W-1:0] cnt_q;
   logic [MS_W-1:0] cur_lim;
   logic            svc_ok, svc_bad, at_end, expire, closed;
   logic            renew, fault, irq_next;

   always_comb begin
      svc_ok  = svc_valid && (svc_code == SVC_KEY);
      svc_bad = svc_valid && !svc_ok;
      off_run = (phase_q == PH_RUN) && (eff_mode == WM_OFF);

      if (phase_q == PH_START) cur_lim = MS_W'(INIT_MS);
      else if (off_run)        cur_lim = MS_W'(LONGEST_MS);
      else                     cur_lim = limit_ms;

      at_end = ({1'b0, cnt_q} + (MS_W+1)'(1)) >= {1'b0, cur_lim};
      expire = ms_tick && at_end;
      closed = (phase_q == PH_RUN) && (eff_mode == WM_WINDOW) && (cnt_q < (cur_lim >> 1));

      // A good service or a legal reconfiguration outranks a coinciding expiry.
      renew    = (svc_ok && !off_run) || (cfg_restart && phase_q == PH_RUN);
      fault    = cfg_illegal ||
                 (!off_run && (svc_bad || (svc_ok && closed) || (expire && !renew)));
      irq_next = off_run && expire && !renew && !cfg_illegal;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_START;
         cnt_q   <= '0;
         rst_req <= 1'b0;
         irq     <= 1'b0;
         caused  <= 1'b0;
      end else begin
         rst_req <= fault;
         irq     <= irq_next;
         if (fault)        caused <= 1'b1;
         else if (stat_rd) caused <= 1'b0;

         if (fault) begin
            phase_q <= PH_START;
            cnt_q   <= '0;
         end else if (renew) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
         end else if (irq_next) begin
            cnt_q   <= '0;
         end else if (ms_tick) begin
            cnt_q   <= cnt_q + MS_W'(1);
         end
      end
   end

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
   import wdog_pkg::*;
#(
   parameter int unsigned      OSC_PER_MS = 512,
   parameter int unsigned      INIT_MS    = 256,
   parameter int unsigned      SVC_W      = 8,
   parameter logic [SVC_W-1:0] SVC_KEY    = 'h5A,
   parameter logic [1:0]       DEF_MODE   = 2'b01,
   parameter int unsigned      DEF_SEL    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   input  logic             svc_valid,
   input  logic [SVC_W-1:0] svc_code,
   input  logic             cfg_valid,
   input  logic [1:0]       cfg_mode,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [1:0]       op_state,
   input  logic             stat_rd,
   output logic             wd_rst_req,
   output logic             wd_irq,
   output logic             wd_caused
);

   localparam int unsigned MAX_MS = (INIT_MS > LONGEST_MS) ? INIT_MS : LONGEST_MS;
   localparam int unsigned MS_W   = $clog2(MAX_MS + 1);
   localparam int unsigned HALF_W = SVC_W / 2;

   if (OSC_PER_MS < 1) begin : g_bad_div
      $error("OSC_PER_MS must be at least 1");
   end
   if (INIT_MS < 2) begin : g_bad_init
      $error("INIT_MS must be at least 2");
   end
   if (SVC_W < 2 || (SVC_W % 2) != 0) begin : g_bad_w
      $error("SVC_W must be even and at least 2");
   end else if (SVC_KEY[SVC_W-1:HALF_W] != ~SVC_KEY[HALF_W-1:0]) begin : g_bad_key
      $error("SVC_KEY upper half must complement its lower half");
   end
   if (DEF_MODE == 2'b11) begin : g_bad_mode
      $error("DEF_MODE must be a legal mode code");
   end
   if (DEF_SEL >= (1 << SEL_W)) begin : g_bad_sel
      $error("DEF_SEL out of range");
   end

   logic            ms_tick;
   wd_mode_e        eff_mode;
   logic [MS_W-1:0] limit_ms;
   logic            cfg_restart, cfg_illegal;
   logic            core_off_run;

   wdog_tickgen #(.OSC_PER_MS(OSC_PER_MS)) i_tickgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .ms_tick  (ms_tick)
   );

   wdog_cfg #(.MS_W(MS_W), .DEF_MODE(DEF_MODE), .DEF_SEL(DEF_SEL)) i_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_valid   (cfg_valid),
      .cfg_mode    (cfg_mode),
      .cfg_sel     (cfg_sel),
      .op_state    (op_state),
      .eff_mode    (eff_mode),
      .limit_ms    (limit_ms),
      .cfg_restart (cfg_restart),
      .cfg_illegal (cfg_illegal)
   );

   wdog_core #(.MS_W(MS_W), .INIT_MS(INIT_MS), .SVC_W(SVC_W), .SVC_KEY(SVC_KEY)) i_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .ms_tick     (ms_tick),
      .svc_valid   (svc_valid),
      .svc_code    (svc_code),
      .eff_mode    (eff_mode),
      .limit_ms    (limit_ms),
      .cfg_restart (cfg_restart),
      .cfg_illegal (cfg_illegal),
      .stat_rd     (stat_rd),
      .rst_req     (wd_rst_req),
      .irq         (wd_irq),
      .caused      (wd_caused),
      .off_run     (core_off_run)
   );

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
   parameter int unsigned      SVC_W   = 8,
   parameter logic [SVC_W-1:0] SVC_KEY = 'h5A
) (
   input logic             clk,
   input logic             rst_n,
   input logic             svc_valid,
   input logic [SVC_W-1:0] svc_code,
   input logic             cfg_valid,
   input logic [1:0]       cfg_mode,
   input logic             stat_rd,
   input logic             wd_rst_req,
   input logic             wd_irq,
   input logic             wd_caused,
   input logic             core_off_run
);

   assert_illegal_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_mode == 2'b11) |=> wd_rst_req)
      else $error("illegal mode write did not request a reset");

   assert_bad_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_valid && svc_code != SVC_KEY && !core_off_run) |=> wd_rst_req)
      else $error("invalid service code did not request a reset");

   assert_flag_on_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_req |-> wd_caused)
      else $error("cause flag not set with reset request");

   assert_read_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (wd_rst_req || !wd_caused))
      else $error("cause flag survived a read");

   assert_irq_only_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wd_irq |-> $past(core_off_run))
      else $error("interrupt outside off mode");

   assert_no_irq_with_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wd_irq && wd_rst_req))
      else $error("interrupt and reset together");

   assert_off_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (core_off_run && !(cfg_valid && cfg_mode == 2'b11)) |=> !wd_rst_req)
      else $error("reset request while off mode running");

endmodule

bind wdog_supervisor wdog_supervisor_chk #(.SVC_W(SVC_W), .SVC_KEY(SVC_KEY)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .svc_valid    (svc_valid),
   .svc_code     (svc_code),
   .cfg_valid    (cfg_valid),
   .cfg_mode     (cfg_mode),
   .stat_rd      (stat_rd),
   .wd_rst_req   (wd_rst_req),
   .wd_irq       (wd_irq),
   .wd_caused    (wd_caused),
   .core_off_run (core_off_run)
);

// File: tb/test_wdog_supervisor.sv
module test_wdog_supervisor;

   localparam int unsigned INIT = 30;
   localparam logic [7:0]  KEY  = 8'h5A;
   localparam logic [7:0]  BAD  = 8'h5B;
   localparam logic [1:0]  M_OFF = 2'b00, M_WIN = 2'b01, M_TMO = 2'b10, M_ILL = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b1;
   logic       svc_valid = 1'b0;
   logic [7:0] svc_code = '0;
   logic       cfg_valid = 1'b0;
   logic [1:0] cfg_mode = '0;
   logic [2:0] cfg_sel = '0;
   logic [1:0] op_state = 2'b00;
   logic       stat_rd = 1'b0;
   logic       wd_rst_req, wd_irq, wd_caused;

   always #10 clk = ~clk;

   wdog_supervisor #(.OSC_PER_MS(1), .INIT_MS(INIT)) i_wdog_supervisor (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_tick   (osc_tick),
      .svc_valid  (svc_valid),
      .svc_code   (svc_code),
      .cfg_valid  (cfg_valid),
      .cfg_mode   (cfg_mode),
      .cfg_sel    (cfg_sel),
      .op_state   (op_state),
      .stat_rd    (stat_rd),
      .wd_rst_req (wd_rst_req),
      .wd_irq     (wd_irq),
      .wd_caused  (wd_caused)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      bit    is_irq;
      int    at;
      string req;
   } ev_t;

   ev_t expq[$];
   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   int  org;

   function automatic void check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // Scoreboard monitor: every pulse must match the head of the queue.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         while (expq.size() > 0 && expq[0].at < cyc) begin
            check(1'b0, expq[0].req, "missing pulse, now at cycle", cyc, expq[0].at);
            void'(expq.pop_front());
         end
         if (wd_rst_req || wd_irq) begin
            if (expq.size() == 0) begin
               check(1'b0, wd_irq ? "R11" : "R6", "unexpected pulse at cycle", cyc, -1);
            end else begin
               ev_t e;
               e = expq.pop_front();
               check(e.at == cyc && e.is_irq == wd_irq && wd_rst_req != wd_irq,
                     e.req, "pulse cycle", cyc, e.at);
            end
         end
      end
   end

   task automatic expect_ev(bit irq, int at, string req);
      ev_t e;
      e.is_irq = irq;
      e.at     = at;
      e.req    = req;
      expq.push_back(e);
   endtask

   task automatic tick_to(int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic svc_at(int c, logic [7:0] code);
      tick_to(c);
      svc_code  = code;
      svc_valid = 1'b1;
      @(negedge clk);
      svc_valid = 1'b0;
   endtask

   task automatic cfg_at(int c, logic [1:0] m, logic [2:0] s);
      tick_to(c);
      cfg_mode  = m;
      cfg_sel   = s;
      cfg_valid = 1'b1;
      @(negedge clk);
      cfg_valid = 1'b0;
   endtask

   // Leave start-up with a valid service two ms after the last origin.
   task automatic rearm();
      svc_at(org + 2, KEY);
      org = org + 3;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R6 watchdog expired: actual %0d expected %0d", cyc, 0);
         finish_run();
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check(wd_rst_req == 1'b0, "R1", "reset request in reset", wd_rst_req, 0);
      check(wd_irq == 1'b0, "R1", "interrupt in reset", wd_irq, 0);
      check(wd_caused == 1'b0, "R1", "cause flag in reset", wd_caused, 0);
      rst_n = 1'b1;
      org   = cyc;

      // R2: start-up period expires without service
      expect_ev(1'b0, org + INIT, "R2");
      tick_to(org + INIT);
      check(wd_caused == 1'b1, "R12", "cause flag after reset request", wd_caused, 1);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      check(wd_caused == 1'b0, "R12", "cause flag after read", wd_caused, 0);
      org = org + INIT;
      svc_at(org + 3, KEY);
      org = org + 4;

      // R4: window closed at 9 of 20 ms
      expect_ev(1'b0, org + 10, "R4");
      svc_at(org + 9, KEY);
      org = org + 10;
      rearm();

      // R5: open window boundary at 10 ms, and the last ms
      svc_at(org + 10, KEY);
      org = org + 11;
      svc_at(org + 19, KEY);
      org = org + 20;

      // R6: expiry after 20 ms
      expect_ev(1'b0, org + 20, "R6");
      tick_to(org + 20);
      org = org + 20;
      rearm();

      // R3: wrong code in open window and in start-up
      expect_ev(1'b0, org + 13, "R3");
      svc_at(org + 12, BAD);
      org = org + 13;
      expect_ev(1'b0, org + 3, "R3");
      svc_at(org + 2, BAD);
      org = org + 3;
      rearm();

      // R13 and R8: reconfigure to time-out, select 2 (80 ms)
      cfg_at(org + 5, M_TMO, 3'd2);
      org = org + 6;
      expect_ev(1'b0, org + 80, "R13");
      tick_to(org + 80);
      org = org + 80;
      rearm();

      // R7: early service accepted in time-out mode
      svc_at(org + 1, KEY);
      org = org + 2;
      expect_ev(1'b0, org + 80, "R7");
      tick_to(org + 80);
      org = org + 80;
      rearm();

      // R10: illegal mode resets and keeps time-out / 80 ms
      expect_ev(1'b0, org + 5, "R10");
      cfg_at(org + 4, M_ILL, 3'd0);
      org = org + 5;
      rearm();
      expect_ev(1'b0, org + 80, "R10");
      tick_to(org + 80);
      org = org + 80;
      rearm();

      // R8: select 7 = 2048 ms, window half at 1024
      cfg_at(org + 1, M_WIN, 3'd7);
      org = org + 2;
      expect_ev(1'b0, org + 1024, "R8");
      svc_at(org + 1023, KEY);
      org = org + 1024;
      rearm();
      svc_at(org + 1024, KEY);
      org = org + 1025;

      // R9: sleep table, window acts as time-out (160 ms)
      op_state = 2'b10;
      cfg_at(org + 1, M_WIN, 3'd0);
      org = org + 2;
      svc_at(org + 2, KEY);
      org = org + 3;
      expect_ev(1'b0, org + 160, "R9");
      tick_to(org + 160);
      org = org + 160;
      rearm();
      cfg_at(org + 1, M_TMO, 3'd5);
      org = org + 2;
      expect_ev(1'b0, org + 3072, "R9");
      tick_to(org + 3072);
      org = org + 3072;
      rearm();

      // R11: off mode, longest period, interrupt only, services ignored
      op_state = 2'b11;
      cfg_at(org + 1, M_OFF, 3'd0);
      org = org + 2;
      svc_at(org + 5, BAD);
      expect_ev(1'b1, org + 28672, "R11");
      tick_to(org + 28672);
      repeat (5) @(negedge clk);
      check(expq.size() == 0, "R11", "pending expectations", expq.size(), 0);
      finish_run();
   end

endmodule